// File: doc/BRIEF.md
# Clock Request Stop Gating

This block sits between a free-running clock and a bank of differential clock outputs that share one domain. Each output can be stopped and restarted by two asynchronous active-low request pins, by a hardware stop pin, and by a software run bit. A pair of per-output mask vectors selects which request pin may stop which output. A third mask selects the outputs that obey the stop pin and the software bit; the others run freely. Each output is a true/complement pair running at half the input clock rate. All outputs share a single phase register, so every running output is in phase with every other.

Stops and restarts are clean. A stopped output parks LOW only after it completes its current high pulse. It restarts at the start of a full high pulse, on the same cycle as every other output released by the same event. One drive-mode input picks what a parked output does. Either it keeps driving (true LOW, complement HIGH), or it releases both legs through its drive enables. Request pins pass through a synchronizer and a debounce that needs two agreeing samples, so a one-cycle glitch never moves an output.

Top module: `clkreq_gate`

## Requirements
- R1: A request pin level is accepted only after it has been seen unchanged on two consecutive synchronized samples. A pin pulse lasting one clock cycle moves no output, and a pulse held for two cycles is accepted.
- R2: Driving a request pin HIGH stops every output whose bit for that pin is set in its map. The output finishes its current high pulse and then stays LOW from the 6th falling clock edge after the pin change for as long as the pin stays HIGH.
- R3: Driving a request pin LOW restarts its mapped, otherwise unstopped outputs. The first rising output edge is seen on the 6th or 7th falling clock edge after the pin change. All outputs released by one event rise on the same cycle, in phase with the free-running outputs.
- R4: `map_a[i]` and `map_b[i]` each set whether pin A and pin B respectively can stop output i. An output with both bits clear keeps toggling whatever the pins do.
- R5: The package provides reset values for the maps. Pin A controls output 4 (`map_a` = 8'h10) and pin B controls output 5 (`map_b` = 8'h20).
- R6: The stop condition is active when `stop_n` is LOW or `sw_run` is 0. It stops only the outputs with `stop_en[i]` = 1. Outputs with `stop_en[i]` = 0 keep running.
- R7: After `sw_run` falls, stoppable outputs are LOW from the 2nd falling edge. After it rises, they first rise on the 2nd or 3rd falling edge. After `stop_n` falls, stoppable outputs are LOW from the 4th falling edge. No short pulse appears in either case.
- R8: When `park_hiz` = 1, a parked output has `oe_t` = `oe_c` = 0. When `park_hiz` = 0, it stays driven with `clk_t` = 0 and `clk_c` = 1. Running outputs are always driven, with `clk_c` the inverse of `clk_t`.
- R9: An output is stopped when any of its enabled sources (pin A, pin B, or the stop condition) is active. It runs again only when none is.
- R10: While reset is held, every `clk_t` is 0, every `clk_c` is 1 and every drive enable is 1. The debounced request state resets to "requested".
- R11: A running output is HIGH for exactly one clock cycle and then LOW for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_a_n | input | 1 | Asynchronous clock request pin A, active LOW |
| req_b_n | input | 1 | Asynchronous clock request pin B, active LOW |
| stop_n | input | 1 | Asynchronous hardware stop pin, active LOW |
| sw_run | input | 1 | Software run bit, 0 stops stoppable outputs |
| map_a | input | N_OUT | Per-output enable for stopping by pin A |
| map_b | input | N_OUT | Per-output enable for stopping by pin B |
| stop_en | input | N_OUT | Per-output enable for the stop condition |
| park_hiz | input | 1 | Parked outputs: 0 driven LOW, 1 released |
| clk_t | output | N_OUT | True leg of each output |
| clk_c | output | N_OUT | Complement leg of each output |
| oe_t | output | N_OUT | Drive enable of each true leg |
| oe_c | output | N_OUT | Drive enable of each complement leg |

## Verification
The bench drives single-cycle and two-cycle pulses on a request pin. A design without a working debounce would drop or restore an output on the glitch. It measures stop and restart latency from each source. Every high pulse is checked against the always-running output 0, so a design that restarted mid-phase would show a high level that output 0 lacks. A design that cut a pulse short or stretched it on stop would show a high lasting two samples, or a high out of phase with output 0. Several outputs are released by one pin edge to catch staggered restarts. Random map, source and drive-mode settings compare each output's settled state and drive enables against an expected stop function of the inputs.

// File: rtl/clkreq_pkg.sv
// Shared constants and types for the clock request stop gating block.
// Assumes at most eight outputs when the reset maps are used as-is.
package clkreq_pkg;

    localparam int unsigned CLKREQ_LANES = 8;

    // Reset values of the request maps held by the register block
    localparam logic [7:0] CLKREQ_MAP_A_RST = 8'h10;
    localparam logic [7:0] CLKREQ_MAP_B_RST = 8'h20;

    typedef enum logic {
        PARK_DRIVEN = 1'b0,
        PARK_HIZ    = 1'b1
    } park_mode_e;

    // Debounced / synchronized stop sources shared by every lane
    typedef struct packed {
        logic pin_a_idle;
        logic pin_b_idle;
        logic stop_any;
    } halt_src_t;

endpackage

// File: rtl/clkreq_sync.sv
// Multi-flop synchronizer for asynchronous level inputs.
// Assumes STAGES >= 2; each bit is synchronized independently.
module clkreq_sync #(
    parameter int unsigned STAGES  = 2,
    parameter int unsigned WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) chain[s] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/clkreq_debounce.sv
// Synchronizes an active-low request pin and accepts a new level only when
// two consecutive synchronized samples agree. Output is 1 when the pin is
// accepted as HIGH (request withdrawn). Assumes the pin is fully asynchronous.
module clkreq_debounce #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        RST_LVL     = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic idle
);

    logic lvl;
    logic prev_q;
    logic acc_q;

    clkreq_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (1),
        .RST_VAL (RST_LVL)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_n),
        .q     (lvl)
    );

    // Keep the last synchronized sample and accept a level seen twice
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= RST_LVL;
            acc_q  <= RST_LVL;
        end else begin
            prev_q <= lvl;
            if (lvl == prev_q) acc_q <= lvl;
        end
    end

    assign idle = acc_q;

    AST_ACCEPT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_q) |-> ($past(lvl) == $past(prev_q))); // R1

endmodule

// File: rtl/clkreq_lane.sv
// One gated differential output. A running lane copies the shared half-rate
// phase; a stop takes effect only while the output is LOW, so pulses are
// never shortened, and a restart waits for the next rising phase slot.
// Assumes phase toggles every clock cycle.
module clkreq_lane
    import clkreq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase,
    input  logic       halt,
    input  park_mode_e park,
    output logic       out_t,
    output logic       out_c,
    output logic       drv_t,
    output logic       drv_c
);

    logic run_q;
    logic out_q;
    logic parked;

    // Register the stop decision once per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b1;
        else        run_q <= ~halt;
    end

    // Rise only on a rising phase slot while running, always fall otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= ~phase & run_q;
    end

    assign parked = ~run_q & ~out_q;
    assign out_t  = out_q;
    assign out_c  = ~out_q;
    assign drv_t  = ~(parked & (park == PARK_HIZ));
    assign drv_c  = drv_t;

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |=> !out_q); // R11
    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !out_q) |=> !out_q); // R2
    AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q) |-> $past(run_q)); // R3

endmodule

// File: rtl/clkreq_gate.sv
// Top of the clock request stop gating block. Builds the shared half-rate
// phase, conditions the request and stop pins, combines every stop source
// per output through its masks and instantiates one gated lane per output.
// Assumes map and enable inputs come from a register block in this domain.
module clkreq_gate
    import clkreq_pkg::*;
#(
    parameter int unsigned N_OUT       = CLKREQ_LANES,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_a_n,
    input  logic             req_b_n,
    input  logic             stop_n,
    input  logic             sw_run,
    input  logic [N_OUT-1:0] map_a,
    input  logic [N_OUT-1:0] map_b,
    input  logic [N_OUT-1:0] stop_en,
    input  logic             park_hiz,
    output logic [N_OUT-1:0] clk_t,
    output logic [N_OUT-1:0] clk_c,
    output logic [N_OUT-1:0] oe_t,
    output logic [N_OUT-1:0] oe_c
);

    logic       ph_q;
    logic       stop_lvl;
    halt_src_t  src;
    park_mode_e park;
    logic [N_OUT-1:0] halt;

    // Shared half-rate phase that every running lane follows
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    clkreq_debounce #(.SYNC_STAGES(SYNC_STAGES), .RST_LVL(1'b0)) u_deb_a (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (req_a_n),
        .idle  (src.pin_a_idle)
    );

    clkreq_debounce #(.SYNC_STAGES(SYNC_STAGES), .RST_LVL(1'b0)) u_deb_b (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (req_b_n),
        .idle  (src.pin_b_idle)
    );

    clkreq_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b1)) u_stop_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stop_n),
        .q     (stop_lvl)
    );

    // Merge hardware and software stop into one source
    always_comb begin
        src.stop_any = ~stop_lvl | ~sw_run;
        park         = park_mode_e'(park_hiz);
    end

    for (genvar i = 0; i < int'(N_OUT); i++) begin : g_lane
        // Any enabled source stops this lane
        always_comb begin
            halt[i] = (map_a[i]   & src.pin_a_idle)
                    | (map_b[i]   & src.pin_b_idle)
                    | (stop_en[i] & src.stop_any);
        end

        clkreq_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .phase (ph_q),
            .halt  (halt[i]),
            .park  (park),
            .out_t (clk_t[i]),
            .out_c (clk_c[i]),
            .drv_t (oe_t[i]),
            .drv_c (oe_c[i])
        );

        AST_SW_STOP_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!sw_run && stop_en[i]) && !sw_run && stop_en[i])
            |=> !clk_t[i]); // R7
    end

endmodule

// File: tb/clkreq_gate_bench.sv
module clkreq_gate_bench;
    import clkreq_pkg::*;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_a_n = 1'b0, req_b_n = 1'b0, stop_n = 1'b1, sw_run = 1'b1;
    logic [N-1:0] map_a = CLKREQ_MAP_A_RST, map_b = CLKREQ_MAP_B_RST;
    logic [N-1:0] stop_en = '0;
    logic park_hiz = 1'b0;
    logic [N-1:0] clk_t, clk_c, oe_t, oe_c;

    int n_chk = 0, n_fail = 0;
    bit mon_on = 1'b0, done = 1'b0;
    logic [N-1:0] prev_t = '0;
    int rise_at [N];

    always #2 clk = ~clk;

    clkreq_gate u_clkreq_gate (
        .clk(clk), .rst_n(rst_n), .req_a_n(req_a_n), .req_b_n(req_b_n),
        .stop_n(stop_n), .sw_run(sw_run), .map_a(map_a), .map_b(map_b),
        .stop_en(stop_en), .park_hiz(park_hiz), .clk_t(clk_t), .clk_c(clk_c),
        .oe_t(oe_t), .oe_c(oe_c)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected stop state of one lane from the requirement R9 combination
    function automatic bit exp_stop(input int i);
        return (map_a[i] && req_a_n) || (map_b[i] && req_b_n) ||
               (stop_en[i] && (!stop_n || !sw_run));
    endfunction

    // Continuous pulse-shape, phase and complement monitor (R11, R3, R8)
    always @(negedge clk) begin
        if (mon_on) begin
            for (int i = 0; i < N; i++) begin
                check(!(clk_t[i] && prev_t[i]), "R11", $sformatf("lane %0d high twice", i),
                      int'(prev_t[i]), 0);
                check(!clk_t[i] || clk_t[0], "R3", $sformatf("lane %0d out of phase", i),
                      int'(clk_t[0]), 1);
                check(!oe_t[i] || (clk_c[i] == ~clk_t[i]), "R8",
                      $sformatf("lane %0d complement", i), int'(clk_c[i]), int'(~clk_t[i]));
            end
            prev_t = clk_t;
        end
    end

    task automatic settle_check(input string req);
        logic [N-1:0] a, b, oa;
        repeat (14) @(negedge clk);
        a = clk_t;
        oa = oe_t;
        @(negedge clk);
        b = clk_t;
        for (int i = 0; i < N; i++) begin
            if (exp_stop(i)) begin
                check(!a[i] && !b[i], req, $sformatf("lane %0d parked", i),
                      int'(a[i] | b[i]), 0);
                check(oa[i] == ~park_hiz && oe_c[i] == ~park_hiz, "R8",
                      $sformatf("lane %0d drive", i), int'(oa[i]), int'(~park_hiz));
            end else begin
                check(a[i] != b[i], req, $sformatf("lane %0d toggling", i),
                      int'(b[i]), int'(~a[i]));
                check(oa[i] && oe_c[i], "R8", $sformatf("lane %0d driven", i),
                      int'(oa[i]), 1);
            end
        end
    endtask

    task automatic expect_low(input int lane, input int from, input int to, input string req);
        bit bad = 1'b0;
        for (int c = 1; c <= to; c++) begin
            @(negedge clk);
            if (c >= from && clk_t[lane]) bad = 1'b1;
        end
        check(!bad, req, $sformatf("lane %0d low window", lane), int'(bad), 0);
    endtask

    task automatic rise_times(input logic [N-1:0] lanes);
        for (int i = 0; i < N; i++) rise_at[i] = -1;
        for (int c = 1; c <= 20; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++)
                if (lanes[i] && rise_at[i] < 0 && clk_t[i]) rise_at[i] = c;
        end
    endtask

    initial begin
        int unused_seed;
        bit bad;
        bit low2;
        unused_seed = int'($urandom(32'hC10C));
        // R10: reset state
        repeat (3) @(negedge clk);
        check(clk_t == '0, "R10", "true legs in reset", int'(clk_t), 0);
        check(clk_c == '1, "R10", "complement legs in reset", int'(clk_c), 255);
        check(oe_t == '1 && oe_c == '1, "R10", "drive in reset", int'(oe_t), 255);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;
        settle_check("R10");

        // R5/R2: default map, withdraw pin A stops lane 4 only
        req_a_n = 1'b1;
        expect_low(4, 6, 20, "R2");
        settle_check("R5");
        // R3: restart latency
        req_a_n = 1'b0;
        rise_times(8'h10);
        check(rise_at[4] == 6 || rise_at[4] == 7, "R3", "restart latency", rise_at[4], 6);
        req_b_n = 1'b1;
        settle_check("R5");
        req_b_n = 1'b0;
        settle_check("R5");

        // R4/R3: remapped lanes restart together
        map_a = 8'b0000_1100; map_b = 8'b0100_0000;
        req_a_n = 1'b1; req_b_n = 1'b1;
        settle_check("R4");
        req_a_n = 1'b0; req_b_n = 1'b0;
        rise_times(8'b0100_1100);
        check(rise_at[2] == rise_at[3] && rise_at[3] == rise_at[6], "R3",
              "simultaneous restart", rise_at[6], rise_at[2]);
        check(rise_at[2] == 6 || rise_at[2] == 7, "R3", "group latency", rise_at[2], 6);

        // R1: one-cycle glitches ignored, two-cycle pulse accepted
        map_a = CLKREQ_MAP_A_RST; map_b = CLKREQ_MAP_B_RST;
        req_a_n = 1'b1;
        settle_check("R1");
        req_a_n = 1'b0; @(negedge clk); req_a_n = 1'b1;
        expect_low(4, 1, 14, "R1");
        req_a_n = 1'b0;
        settle_check("R1");
        req_a_n = 1'b1; @(negedge clk); req_a_n = 1'b0;
        bad = 1'b0;
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            if (!clk_t[4] && !prev_t[4]) bad = 1'b1;
        end
        check(!bad, "R1", "running lane after glitch", int'(bad), 0);
        req_a_n = 1'b1; @(negedge clk); @(negedge clk); req_a_n = 1'b0;
        low2 = 1'b0;
        begin
            logic last = clk_t[4];
            for (int c = 0; c < 14; c++) begin
                @(negedge clk);
                if (!clk_t[4] && !last) low2 = 1'b1;
                last = clk_t[4];
            end
        end
        check(low2, "R1", "two-cycle pulse accepted", int'(low2), 1);
        settle_check("R1");

        // R6/R7: software and hardware stop
        stop_en = 8'b1010_1010;
        sw_run = 1'b0;
        expect_low(1, 2, 10, "R7");
        settle_check("R6");
        sw_run = 1'b1;
        rise_times(8'b1010_1010);
        check(rise_at[1] == 2 || rise_at[1] == 3, "R7", "software release", rise_at[1], 2);
        check(rise_at[1] == rise_at[7], "R3", "release aligned", rise_at[7], rise_at[1]);
        stop_n = 1'b0;
        expect_low(5, 4, 12, "R7");
        settle_check("R6");
        stop_n = 1'b1;
        settle_check("R6");

        // R9: any enabled source stops
        map_a = 8'b0000_0010; map_b = '0; stop_en = 8'b0000_0010;
        stop_n = 1'b0;
        settle_check("R9");
        stop_n = 1'b1;
        settle_check("R9");
        req_a_n = 1'b1;
        settle_check("R9");
        req_a_n = 1'b0;

        // R8: drive modes on parked lanes
        park_hiz = 1'b1; sw_run = 1'b0; stop_en = 8'b1111_1110;
        settle_check("R8");
        park_hiz = 1'b0;
        settle_check("R8");
        sw_run = 1'b1;

        // Random mix, lane 0 kept free running as the phase reference
        for (int it = 0; it < 40; it++) begin
            map_a   = 8'($urandom) & 8'hFE;
            map_b   = 8'($urandom) & 8'hFE;
            stop_en = 8'($urandom) & 8'hFE;
            req_a_n = 1'($urandom); req_b_n = 1'($urandom);
            stop_n  = 1'($urandom); sw_run  = 1'($urandom);
            park_hiz = 1'($urandom);
            settle_check("R9");
        end

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule